// File: doc/BRIEF.md
# Burst Mode Light-Load Controller

This block runs a primary-regulated converter through no-load and very-light-load conditions. It watches two comparator flags formed from the error-amplifier output. The first says that the output has fallen below the burst threshold less its hysteresis. The second says that it has risen above the lower re-enable level. When the light-load flag holds steady, switching stops. A low-power indicator then tells the peak-current logic to hold its limit at the small, near-constant level set by the disable threshold.

While it rests, the block raises a short probe request once per fixed interval (500 µs by default). Each probe makes the converter switch once, so that the output voltage is measured again. After a settle delay the block looks at the re-enable flag once. If the flag is high, normal switching resumes. If not, the block rests for another full interval. A protection stop, like reset, returns the block at once to normal switching and clears its timers.

The machine has four states. RUN is normal switching. REST means switching is off while the block waits out the interval. PROBE drives the probe request. SETTLE waits before the decision. The transitions are:
- RUN→REST on a filtered light-load flag.
- REST→PROBE when the interval expires.
- PROBE→SETTLE when the pulse time ends.
- SETTLE→RUN or SETTLE→REST on the re-enable flag at the end of the settle time.
- Any state→RUN on the protection stop.

Top module: `burst_ctrl`

## Requirements
- R1: After reset, sw_en is 1, and probe_req and low_pwr are both 0.
- R2: In RUN, once comp_low is sampled high at two consecutive rising edges, the block enters REST: low_pwr goes to 1 and sw_en goes to 0 on the third rising edge after comp_low is first driven high.
- R3: A comp_low high for a single clock sample is ignored, and low_pwr stays 0.
- R4: The first rising edge of probe_req comes exactly PROBE_CYCLES clock cycles after REST is entered, that is, after low_pwr rises.
- R5: probe_req stays high for exactly PULSE_CYCLES cycles. Throughout the pulse, sw_en stays 0 and low_pwr stays 1.
- R6: If the filtered comp_ok is 1 when SETTLE ends, low_pwr falls and sw_en rises exactly SETTLE_CYCLES cycles after probe_req falls.
- R7: If the filtered comp_ok is 0 when SETTLE ends, the block returns to REST. The next probe_req rise comes SETTLE_CYCLES + PROBE_CYCLES cycles after the previous fall, and low_pwr stays 1 throughout.
- R8: comp_ok is read only at the end of SETTLE. A comp_ok that goes high during REST and drops before the probe does not end burst mode.
- R9: prot_stop high at a rising edge puts the block in RUN on that edge (sw_en=1, low_pwr=0, probe_req=0), even on the edge where a probe would start. All timers are cleared, so a later entry waits a full PROBE_CYCLES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_stop | input | 1 | Protection stop; forces normal state and clears timers |
| comp_low | input | 1 | Error-amp output below burst threshold minus hysteresis |
| comp_ok | input | 1 | Error-amp output above the re-enable level |
| sw_en | output | 1 | Switching enable (1 in RUN) |
| probe_req | output | 1 | Request for one probe switching pulse |
| low_pwr | output | 1 | Burst/low-power indicator; also clamps peak current |

## Verification
Two events can land on the same edge: the expiry of the rest interval, which starts a probe, and a protection stop. The bench counts cycles from the rise of low_pwr. It raises prot_stop in the last REST cycle, so the stop and the probe start fall on the same edge. The stop must win: probe_req must never rise, and the block must be in RUN one cycle later. A second stop in the middle of an interval, followed by a new entry, shows that the timer was cleared, because the new interval is measured at its full length.

// File: rtl/bm_pkg.sv
package bm_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_REST   = 2'd1,
        ST_PROBE  = 2'd2,
        ST_SETTLE = 2'd3
    } bm_state_t;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/bm_flag_filter.sv
// Two-sample agreement filter: output follows input only after the same
// value is seen at two consecutive rising edges.
module bm_flag_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic raw,
    output logic filt
);
    logic smp;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            smp  <= 1'b0;
            filt <= 1'b0;
        end else begin
            smp <= raw;
            if (raw == smp) filt <= raw;
        end
    end

    // R3: a rise of the filtered flag needs the flag high on two samples
    assert_filter_two_samples_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(filt) |-> $past(raw && smp));

endmodule

// File: rtl/bm_interval_timer.sv
// Shared cycle counter; tc marks the last cycle of the current window.
module bm_interval_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] lim,
    output logic         tc
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end

    assign tc = (cnt == lim - 1'b1);

    // R4: the count never runs past its window
    assert_count_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < lim);

endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl #(
    parameter int unsigned PROBE_CYCLES  = 100000, // 500 us at 200 MHz
    parameter int unsigned PULSE_CYCLES  = 4,
    parameter int unsigned SETTLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prot_stop,
    input  logic comp_low,
    input  logic comp_ok,
    output logic sw_en,
    output logic probe_req,
    output logic low_pwr
);
    import bm_pkg::*;

    localparam int unsigned MAXC  = max3(PROBE_CYCLES, PULSE_CYCLES, SETTLE_CYCLES);
    localparam int unsigned CNT_W = $clog2(MAXC + 1);
    localparam int unsigned NFLAG = 2;

    bm_state_t          state, nxt;
    logic [NFLAG-1:0]   raw_v, filt_v;
    logic               low_f, ok_f, tc, tclr;
    logic [CNT_W-1:0]   lim;

    assign raw_v = {comp_ok, comp_low};

    for (genvar g = 0; g < NFLAG; g++) begin : g_filt
        bm_flag_filter u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (prot_stop),
            .raw  (raw_v[g]),
            .filt (filt_v[g])
        );
    end

    assign low_f = filt_v[0];
    assign ok_f  = filt_v[1];

    always_comb begin
        unique case (state)
            ST_REST:   lim = CNT_W'(PROBE_CYCLES);
            ST_PROBE:  lim = CNT_W'(PULSE_CYCLES);
            ST_SETTLE: lim = CNT_W'(SETTLE_CYCLES);
            ST_RUN:    lim = CNT_W'(MAXC);
        endcase
    end

    assign tclr = prot_stop || (state == ST_RUN) || (nxt != state);

    bm_interval_timer #(.W(CNT_W)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tclr),
        .lim  (lim),
        .tc   (tc)
    );

    // next-state logic; protection stop has top priority
    always_comb begin
        nxt = state;
        if (prot_stop) begin
            nxt = ST_RUN;
        end else begin
            unique case (state)
                ST_RUN:    if (low_f) nxt = ST_REST;
                ST_REST:   if (tc)    nxt = ST_PROBE;
                ST_PROBE:  if (tc)    nxt = ST_SETTLE;
                ST_SETTLE: if (tc)    nxt = ok_f ? ST_RUN : ST_REST;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    // outputs
    always_comb begin
        sw_en     = 1'b0;
        probe_req = 1'b0;
        low_pwr   = 1'b0;
        unique case (state)
            ST_RUN:    sw_en = 1'b1;
            ST_REST:   low_pwr = 1'b1;
            ST_PROBE: begin
                low_pwr   = 1'b1;
                probe_req = 1'b1;
            end
            ST_SETTLE: low_pwr = 1'b1;
        endcase
    end

    assert_prot_forces_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        prot_stop |=> (sw_en && !low_pwr && !probe_req));

    assert_entry_needs_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(low_pwr) |-> $past(low_f));

    assert_probe_after_interval_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(probe_req) |-> $past(state == ST_REST && tc));

    assert_exit_needs_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(low_pwr) && !$past(prot_stop)) |-> $past(ok_f && state == ST_SETTLE));

endmodule

// File: tb/tb_burst_ctrl.sv
`timescale 1ns/1ps
module tb_burst_ctrl;
    localparam int I = 200;
    localparam int P = 3;
    localparam int S = 8;

    logic clk = 1'b0;
    logic rst_n, prot_stop, comp_low, comp_ok;
    logic sw_en, probe_req, low_pwr;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    burst_ctrl #(.PROBE_CYCLES(I), .PULSE_CYCLES(P), .SETTLE_CYCLES(S)) dut (
        .clk(clk), .rst_n(rst_n), .prot_stop(prot_stop), .comp_low(comp_low),
        .comp_ok(comp_ok), .sw_en(sw_en), .probe_req(probe_req), .low_pwr(low_pwr)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic enter_burst();
        @(negedge clk) comp_low = 1'b1;
        do @(negedge clk); while (!low_pwr);
        comp_low = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "sw_en after reset", sw_en, 1);
        check("R1", "probe_req after reset", probe_req, 0);
        check("R1", "low_pwr after reset", low_pwr, 0);
    endtask

    task automatic t_glitch();
        @(negedge clk) comp_low = 1'b1;
        @(negedge clk) comp_low = 1'b0;
        repeat (5) @(negedge clk);
        check("R3", "low_pwr after 1-sample glitch", low_pwr, 0);
    endtask

    task automatic t_entry();
        @(negedge clk) comp_low = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R2", "low_pwr after two edges", low_pwr, 0);
        @(negedge clk);
        comp_low = 1'b0;
        check("R2", "low_pwr after third edge", low_pwr, 1);
        check("R2", "sw_en in burst", sw_en, 0);
    endtask

    task automatic t_interval();
        int n = 0;
        do begin @(negedge clk); n++; end while (!probe_req && n < 10*I);
        check("R4", "cycles from entry to probe", n, I);
    endtask

    task automatic t_probe_width(input bit raise_ok);
        int w = 0;
        int bad = 0;
        if (raise_ok) comp_ok = 1'b1;
        while (probe_req && w < 10*P) begin
            if (sw_en || !low_pwr) bad++;
            w++;
            @(negedge clk);
        end
        check("R5", "probe width", w, P);
        check("R5", "bad sw_en/low_pwr during probe", bad, 0);
    endtask

    task automatic t_stay_off();
        int n = 0;
        int dropped = 0;
        do begin
            @(negedge clk); n++;
            if (n == 20) comp_ok = 1'b1;
            if (n == 60) comp_ok = 1'b0;
            if (!low_pwr) dropped++;
        end while (!probe_req && n < 10*I);
        check("R7", "cycles from probe end to next probe", n, S + I);
        check("R8", "low_pwr dropped by early comp_ok", dropped, 0);
    endtask

    task automatic t_exit();
        int n = 0;
        do begin @(negedge clk); n++; end while (low_pwr && n < 10*I);
        check("R6", "cycles from probe end to exit", n, S);
        check("R6", "sw_en after exit", sw_en, 1);
        comp_ok = 1'b0;
    endtask

    task automatic t_prot_collision();
        int seen = 0;
        enter_burst();
        repeat (I - 1) begin
            @(negedge clk);
            if (probe_req) seen++;
        end
        prot_stop = 1'b1;
        @(negedge clk);
        prot_stop = 1'b0;
        if (probe_req) seen++;
        check("R9", "probe_req on collision", seen, 0);
        check("R9", "low_pwr after stop", low_pwr, 0);
        check("R9", "sw_en after stop", sw_en, 1);
    endtask

    task automatic t_prot_clears_timer();
        enter_burst();
        repeat (I / 2) @(negedge clk);
        prot_stop = 1'b1;
        @(negedge clk) prot_stop = 1'b0;
        check("R9", "low_pwr after mid-interval stop", low_pwr, 0);
        enter_burst();
        begin
            int n = 0;
            do begin @(negedge clk); n++; end while (!probe_req && n < 10*I);
            check("R9", "full interval after stop", n, I);
        end
    endtask

    initial begin
        rst_n = 1'b0; prot_stop = 1'b0; comp_low = 1'b0; comp_ok = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_glitch();
        t_entry();
        t_interval();
        t_probe_width(1'b0);
        t_stay_off();
        t_probe_width(1'b1);
        t_exit();
        t_prot_collision();
        t_prot_clears_timer();
        repeat (5) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule